// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block produces the byte a parallel flash device places on its data bus when it is read while an internal program or erase is running. An external sequencer marks the start of an internal operation with a one-cycle pulse. That pulse stands for the rising edge of the final write strobe of the command. Along with it come the operation kind and the byte being programmed. A second one-cycle pulse marks the end of the operation. Between the two pulses, every qualified read returns status instead of array contents. Bit 7 is a polling bit whose value depends on the operation. Bit 6 flips on every read.

When the operation ends, bit 7 shows its final value at once. The remaining bits need a configurable number of further reads before the whole byte is valid. After that, reads return the true array byte, which is supplied on an input. A read is one cycle of the read strobe with chip select and output enable both high. Its result is registered and appears on the following cycle with a valid flag.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset, `bus_byte_o` is all zeros, `bus_valid_o` is low, and no operation is in progress.
- R2: A read counts only in a cycle where `rd_stb_i`, `chip_sel_i` and `out_en_i` are all high. Each such read raises `bus_valid_o` for exactly the next cycle and updates `bus_byte_o` in that cycle. In a cycle with no counted read, `bus_valid_o` is low the next cycle and `bus_byte_o` keeps its value. A read that does not count leaves the toggle state unchanged.
- R3: During a program operation (`op_erase_i`=0 at start), bit 7 of each read returns the inverse of bit 7 of the byte captured at the start pulse.
- R4: During an erase operation (`op_erase_i`=1 at start), bit 7 of each read returns 0.
- R5: During any operation, bit 6 alternates on each counted read, and the first read after the start pulse returns 1.
- R6: During an operation, bits 5 down to 0 of each read are 0.
- R7: After the done pulse, the next SETTLE_READS counted reads return only bit 7, with bits 6..0 at 0. Bit 7 is 1 after an erase, and after a program it is the captured byte's bit 7. Later reads return `array_byte_i` unchanged.
- R8: A start pulse while an operation is in progress is ignored, including its kind and byte. A done pulse while no operation is in progress is ignored and does not reload the settling count.
- R9: A start pulse accepted during the settling window cancels the remaining settling reads. The new operation's toggle sequence begins again at 1.
- R10: A read in the same cycle as an accepted start pulse returns the state from before the start. Status begins with the next read. A read in the same cycle as the done pulse still returns status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start_i | input | 1 | One-cycle pulse: internal operation begins |
| op_erase_i | input | 1 | Operation kind at start: 0 program, 1 erase |
| prog_byte_i | input | DATA_W | Byte being programmed, sampled at start |
| op_done_i | input | 1 | One-cycle pulse: internal operation finished |
| array_byte_i | input | DATA_W | True array byte at the read address |
| chip_sel_i | input | 1 | Chip select, active high |
| out_en_i | input | 1 | Output enable, active high |
| rd_stb_i | input | 1 | Read strobe, active high |
| bus_byte_o | output | DATA_W | Registered byte driven onto the data bus |
| bus_valid_o | output | 1 | High the cycle after a counted read |

## Verification
The bench builds the block with DATA_W=8 and SETTLE_READS=2. With two settling reads, the bench can tell a correctly counted window from one that is cut short or extended by one read. It can also tell whether a stray done pulse reloads the count, and whether a new start cancels the count. Eight-bit data keeps the polling bit at 7 and the toggle bit at 6. This lets the bench use program bytes with either bit-7 value and check that the complement is taken from the captured byte and not from the live input.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } wst_op_e;

    function automatic int cnt_width(input int reads);
        cnt_width = (reads < 1) ? 1 : $clog2(reads + 1);
    endfunction

endpackage

// File: rtl/wst_op_track.sv
module wst_op_track
    import flash_wstat_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SETTLE_READS = 2,
    localparam int CNT_W       = cnt_width(SETTLE_READS),
    localparam int MSB         = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start_i,
    input  logic              op_erase_i,
    input  logic [DATA_W-1:0] prog_byte_i,
    input  logic              op_done_i,
    input  logic              rd_i,
    output logic              busy_o,
    output logic              erase_o,
    output logic              start_acc_o,
    output logic              poll_bit_o,
    output logic              settle_o,
    output logic              true_msb_o
);

    typedef struct packed {
        logic             busy;
        wst_op_e          op;
        logic             msb;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic start_acc, done_acc;

    always_comb begin
        st_d      = st_q;
        start_acc = op_start_i && !st_q.busy;
        done_acc  = op_done_i && st_q.busy;
        if (start_acc) begin
            st_d.busy = 1'b1;
            st_d.op   = op_erase_i ? OP_ERASE : OP_PROG;
            st_d.msb  = prog_byte_i[MSB];
            st_d.cnt  = '0;
        end else if (done_acc) begin
            st_d.busy = 1'b0;
            st_d.cnt  = CNT_W'(SETTLE_READS);
        end else if (!st_q.busy && rd_i && (st_q.cnt != '0)) begin
            st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, op: OP_PROG, msb: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign erase_o     = (st_q.op == OP_ERASE);
    assign start_acc_o = start_acc;
    assign poll_bit_o  = (st_q.op == OP_PROG) ? ~st_q.msb : 1'b0;
    assign settle_o    = (st_q.cnt != '0);
    assign true_msb_o  = (st_q.op == OP_ERASE) ? 1'b1 : st_q.msb;

    // R1: idle after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !busy_o && !settle_o);

    // R3: program polling bit is the inverse of the captured msb
    assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start_i && !busy_o && !op_erase_i) |=> (poll_bit_o == ~$past(prog_byte_i[MSB])));

    // R8: start during an operation changes nothing
    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_start_i && !op_done_i) |=> busy_o && $stable(erase_o) && $stable(poll_bit_o));

    // R8: done while idle does not reload the settling window
    assert_ignore_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && op_done_i && !op_start_i && !settle_o) |=> !settle_o && !busy_o);

    // R7: each idle read inside the window uses up one settling read
    assert_settle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && rd_i && !op_start_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R9: accepted start cancels settling
    assert_start_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> busy_o && !settle_o);

endmodule

// File: rtl/wst_toggle.sv
module wst_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic start_acc_i,
    input  logic busy_i,
    input  logic rd_i,
    output logic tog_bit_o
);

    typedef struct packed {
        logic tog;
    } tog_t;

    tog_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_acc_i) begin
            st_d.tog = 1'b0;
        end else if (busy_i && rd_i) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{tog: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // the value the next busy read will show
    assign tog_bit_o = ~st_q.tog;

    // R5: each busy read flips the toggle state
    assert_tog_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_i && !start_acc_i) |=> (tog_bit_o != $past(tog_bit_o)));

    // R5 / R9: a new operation starts its sequence at 1
    assert_tog_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc_i |=> tog_bit_o);

    // R2: without a counted read the toggle state holds
    assert_tog_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !start_acc_i) |=> $stable(tog_bit_o));

endmodule

// File: rtl/wst_out_reg.sv
module wst_out_reg #(
    parameter int DATA_W = 8,
    localparam int POLL_BIT = DATA_W - 1,
    localparam int TOG_BIT  = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              busy_i,
    input  logic              erase_i,
    input  logic              poll_bit_i,
    input  logic              tog_bit_i,
    input  logic              settle_i,
    input  logic              true_msb_i,
    input  logic [DATA_W-1:0] array_byte_i,
    output logic [DATA_W-1:0] bus_byte_o,
    output logic              bus_valid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] byte_v;
        logic              valid;
    } out_t;

    out_t st_d, st_q;
    logic [DATA_W-1:0] read_val;

    always_comb begin
        read_val = '0;
        if (busy_i) begin
            read_val[POLL_BIT] = poll_bit_i;
            read_val[TOG_BIT]  = tog_bit_i;
        end else if (settle_i) begin
            read_val[POLL_BIT] = true_msb_i;
        end else begin
            read_val = array_byte_i;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_i;
        if (rd_i) begin
            st_d.byte_v = read_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{byte_v: '0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_byte_o  = st_q.byte_v;
    assign bus_valid_o = st_q.valid;

    // R2: a counted read produces a valid byte one cycle later
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> bus_valid_o);

    // R2: no read, no valid, bus byte held
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !bus_valid_o && $stable(bus_byte_o));

    // R4: erase reports zero on the polling bit
    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_i && erase_i) |=> !bus_byte_o[POLL_BIT]);

    // R6: low bits are zero during an operation
    assert_busy_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_i) |=> (bus_byte_o[TOG_BIT-1:0] == '0));

endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen #(
    parameter int DATA_W       = 8,
    parameter int SETTLE_READS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start_i,
    input  logic              op_erase_i,
    input  logic [DATA_W-1:0] prog_byte_i,
    input  logic              op_done_i,
    input  logic [DATA_W-1:0] array_byte_i,
    input  logic              chip_sel_i,
    input  logic              out_en_i,
    input  logic              rd_stb_i,
    output logic [DATA_W-1:0] bus_byte_o,
    output logic              bus_valid_o
);

    logic rd_q;
    logic busy, erase, start_acc, poll_bit, settle, true_msb, tog_bit;

    assign rd_q = rd_stb_i && chip_sel_i && out_en_i;

    wst_op_track #(
        .DATA_W       (DATA_W),
        .SETTLE_READS (SETTLE_READS)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_start_i  (op_start_i),
        .op_erase_i  (op_erase_i),
        .prog_byte_i (prog_byte_i),
        .op_done_i   (op_done_i),
        .rd_i        (rd_q),
        .busy_o      (busy),
        .erase_o     (erase),
        .start_acc_o (start_acc),
        .poll_bit_o  (poll_bit),
        .settle_o    (settle),
        .true_msb_o  (true_msb)
    );

    wst_toggle u_tog (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_acc_i (start_acc),
        .busy_i      (busy),
        .rd_i        (rd_q),
        .tog_bit_o   (tog_bit)
    );

    wst_out_reg #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_i         (rd_q),
        .busy_i       (busy),
        .erase_i      (erase),
        .poll_bit_i   (poll_bit),
        .tog_bit_i    (tog_bit),
        .settle_i     (settle),
        .true_msb_i   (true_msb),
        .array_byte_i (array_byte_i),
        .bus_byte_o   (bus_byte_o),
        .bus_valid_o  (bus_valid_o)
    );

    // R10: a read in the accepted start cycle still reports pre-start state
    assert_start_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && rd_q && !busy && !settle) |=> (bus_byte_o == $past(array_byte_i)));

endmodule

// File: tb/flash_wstat_gen_tb.sv
module flash_wstat_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0, op_erase = 1'b0, op_done = 1'b0;
    logic [7:0] prog_byte = '0, array_byte = '0;
    logic       chip_sel = 1'b0, out_en = 1'b0, rd_stb = 1'b0;
    logic [7:0] bus_byte;
    logic       bus_valid;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    flash_wstat_gen #(.DATA_W(8), .SETTLE_READS(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_start_i   (op_start),
        .op_erase_i   (op_erase),
        .prog_byte_i  (prog_byte),
        .op_done_i    (op_done),
        .array_byte_i (array_byte),
        .chip_sel_i   (chip_sel),
        .out_en_i     (out_en),
        .rd_stb_i     (rd_stb),
        .bus_byte_o   (bus_byte),
        .bus_valid_o  (bus_valid)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // counted read; optional start/done pulse in same cycle
    task automatic rd_chk(input string req, input logic [7:0] exp,
                          input logic with_start = 1'b0, input logic with_done = 1'b0);
        @(negedge clk);
        rd_stb = 1; chip_sel = 1; out_en = 1;
        op_start = with_start; op_done = with_done;
        @(negedge clk);
        rd_stb = 0; chip_sel = 0; out_en = 0; op_start = 0; op_done = 0;
        chk(req, {bus_valid, bus_byte}, {1'b1, exp});
    endtask

    task automatic start_op(input logic erase, input logic [7:0] b);
        @(negedge clk);
        op_start = 1; op_erase = erase; prog_byte = b;
        @(negedge clk);
        op_start = 0; prog_byte = ~b; op_erase = ~erase;
    endtask

    task automatic done_op();
        @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset", {bus_valid, bus_byte}, 9'h000);
        rst_n = 1;
        array_byte = 8'h3C;
        rd_chk("R1 idle read after reset", 8'h3C);
    endtask

    task automatic t_program();
        start_op(1'b0, 8'h5A);
        rd_chk("R5 R3 prog read1", 8'hC0);
        rd_chk("R5 R6 prog read2", 8'h80);
        rd_chk("R5 prog read3", 8'hC0);
        rd_chk("R10 read with done", 8'h80, 1'b0, 1'b1);
        array_byte = 8'h5A;
        rd_chk("R7 settle1 prog", 8'h00);
        rd_chk("R7 settle2 prog", 8'h00);
        rd_chk("R7 full data", 8'h5A);
        start_op(1'b0, 8'hA5);
        rd_chk("R3 prog msb1 read1", 8'h40);
        rd_chk("R3 prog msb1 read2", 8'h00);
        done_op();
        rd_chk("R7 settle msb1", 8'h80);
        rd_chk("R7 settle msb1 b", 8'h80);
        rd_chk("R7 full after", 8'h5A);
    endtask

    task automatic t_erase();
        start_op(1'b1, 8'h00);
        rd_chk("R4 erase read1", 8'h40);
        rd_chk("R4 erase read2", 8'h00);
        rd_chk("R4 erase read3", 8'h40);
        done_op();
        array_byte = 8'hFF;
        rd_chk("R7 erase settle1", 8'h80);
        rd_chk("R7 erase settle2", 8'h80);
        rd_chk("R7 erase data", 8'hFF);
    endtask

    task automatic t_ignore();
        array_byte = 8'h66;
        start_op(1'b0, 8'h00);
        rd_chk("R8 prog first", 8'hC0);
        start_op(1'b1, 8'hFF);
        rd_chk("R8 start while busy ignored", 8'h80);
        done_op();
        rd_chk("R8 settle1", 8'h00);
        done_op();
        rd_chk("R8 settle2", 8'h00);
        rd_chk("R8 stray done did not reload", 8'h66);
    endtask

    task automatic t_qualify();
        logic [7:0] held;
        start_op(1'b0, 8'h80);
        rd_chk("R2 first read", 8'h40);
        for (int k = 0; k < 3; k++) begin
            held = bus_byte;
            @(negedge clk);
            rd_stb = (k != 0); chip_sel = (k != 1); out_en = (k != 2);
            @(negedge clk);
            rd_stb = 0; chip_sel = 0; out_en = 0;
            chk("R2 unqualified read", {bus_valid, bus_byte}, {1'b0, held});
        end
        rd_chk("R2 toggle held across unqualified", 8'h00);
        done_op();
    endtask

    task automatic t_restart();
        array_byte = 8'h12;
        rd_chk("R9 settle before restart", 8'h80);
        rd_chk("R10 read in start cycle", 8'h80, 1'b1, 1'b0);
        rd_chk("R9 toggle restarts at 1", 8'hC0);
        rd_chk("R9 second", 8'h80);
        done_op();
        rd_chk("R9 fresh settle1", 8'h00);
        rd_chk("R9 fresh settle2", 8'h00);
        rd_chk("R9 data", 8'h12);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_program();
                t_erase();
                t_ignore();
                t_qualify();
                // t_restart: start pulse in read cycle uses prog_byte below
                prog_byte = 8'h00; op_erase = 1'b0;
                t_restart();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule